// File: doc/BRIEF.md
# Three-Class Priority Trap Controller

This block decides, each time an instruction completes, whether the processor takes a trap or simply carries on. Three classes of event compete for service. In priority order they are processor fault, operator/contingency, and peripheral (I/O). Each class owns a bank of sticky cause indicators and a hidden in-service flag. Taking a trap sets that class's in-service flag. The flag then masks further traps of the same class and of every class below it, while higher classes stay enabled and indicators keep collecting events.

On a completion pulse the controller produces one registered decision record, one cycle later. When a trap is taken, the record carries two fixed low-memory addresses: the slot that receives the return word and the slot to jump to. It also carries the return word itself, which is the current program counter zero-extended to the full word. When no trap is taken, the record gives the program counter as the next fetch address.

Software has three other controls. A per-class clear command wipes that class's indicators and in-service flag, and it holds off all traps at the next completion. A level inhibit suppresses peripheral traps. A second processor fault that arrives while a fault trap is in service stops the machine.

There is no back-pressure on the decision record. It is a single-cycle valid strobe, and the consumer (fetch and store logic) must accept it in that cycle, because at most one record is produced per completion pulse.

Top module: `trap_ctrl`

## Requirements
- R1: A decision record (`dec_valid` high for one cycle) appears exactly one cycle after each cycle in which `instr_done` is high and the controller is not halted. No record appears otherwise.
- R2: Among classes that are pending and enabled, the trap taken is processor fault (`dec_class`=0) over contingency (`dec_class`=1) over I/O (`dec_class`=2).
- R3: Taking a trap sets that class's hidden in-service flag. A class is blocked while its own flag or any higher class's flag is set. A lower class's flag never blocks a higher class.
- R4: A taken trap reports `save_addr` 16, 18 or 20 for class 0, 1 or 2 respectively, and `next_addr` = `save_addr` + 1.
- R5: On a taken trap, `save_word` holds the program counter sampled at the completion in bits 14:0, and bits 24:15 are zero.
- R6: Clear command bit k (bit 0 fault, bit 1 contingency, bit 2 I/O) zeroes class k's indicators and in-service flag one cycle later. Other classes are left unchanged.
- R7: After any clear command, the next completion takes no trap. Traps are possible again at the completion after that.
- R8: A processor-fault set request while the fault in-service flag is set raises `halted` on the next cycle. `halted` stays high until reset, and no further decision records are produced.
- R9: While `io_inhibit` is high, no I/O trap is taken, but I/O indicators still latch their set requests.
- R10: When no trap is taken, the record has `dec_take`=0 and `next_addr` equal to the program counter sampled at the completion.
- R11: A set request in the same cycle as a clear of its class wins: the indicator bit ends up set.
- R12: After reset, all indicators are zero, and `dec_valid`, `dec_take` and `halted` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Instruction-completion pulse; triggers a decision |
| cur_pc | input | AW (15) | Address of the next instruction |
| perr_set | input | PE_W (4) | Processor-fault indicator set requests |
| cont_set | input | CT_W (4) | Contingency indicator set requests |
| io_set | input | IO_W (4) | I/O indicator set requests |
| clr_cmd | input | 3 | Per-class clear commands (bit 0 fault, 1 contingency, 2 I/O) |
| io_inhibit | input | 1 | Level inhibit for I/O traps |
| perr_ind | output | PE_W (4) | Processor-fault indicators |
| cont_ind | output | CT_W (4) | Contingency indicators |
| io_ind | output | IO_W (4) | I/O indicators |
| dec_valid | output | 1 | Decision record strobe |
| dec_take | output | 1 | Record is a trap |
| dec_class | output | 2 | Class of the trap taken |
| save_addr | output | AW (15) | Slot for the return word |
| save_word | output | WORD_W (25) | Return word to store |
| next_addr | output | AW (15) | Next fetch address (trap slot or program counter) |
| halted | output | 1 | Machine stopped by a repeated processor fault |

## Verification
The hardest states to reach from the ports are the masking ones. The in-service flags are invisible, so the interesting cases cannot be set up directly: a lower class pending under a higher flag, a higher class pre-empting a lower flag, and a set racing a clear. The stimulus therefore builds them as a long dependent sequence of completions. Each step's result also shows the flag state that the earlier steps left behind. The halt condition is reached by taking a fault trap and then raising a second fault before any clear.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NCLS = 3;

  typedef enum logic [1:0] {
    CLS_PERR = 2'd0,
    CLS_CONT = 2'd1,
    CLS_IO   = 2'd2
  } cls_e;
endpackage

// File: rtl/ind_bank.sv
module ind_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_req,
  input  logic         clr,
  output logic [W-1:0] ind,
  output logic         any
);
  logic [W-1:0] ind_q;

  // set beats clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) ind_q <= '0;
    else        ind_q <= (clr ? '0 : ind_q) | set_req;
  end

  assign ind = ind_q;
  assign any = |ind_q;
endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import trap_pkg::*;
(
  input  logic [NCLS-1:0] pend,
  input  logic [NCLS-1:0] mode,
  input  logic            io_inhibit,
  input  logic            blocked,
  output logic            take,
  output cls_e            cls
);
  logic [NCLS-1:0] enable;

  assign enable = {~io_inhibit, 1'b1, 1'b1};

  always_comb begin
    logic masked;
    take   = 1'b0;
    cls    = CLS_PERR;
    masked = blocked;
    for (int i = 0; i < NCLS; i++) begin
      masked = masked | mode[i];
      if (!masked && pend[i] && enable[i]) begin
        take   = 1'b1;
        cls    = cls_e'(2'(i));
        masked = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int PE_W     = 4,
  parameter int CT_W     = 4,
  parameter int IO_W     = 4,
  parameter int AW       = 15,
  parameter int WORD_W   = 25,
  parameter int VEC_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic [AW-1:0]     cur_pc,
  input  logic [PE_W-1:0]   perr_set,
  input  logic [CT_W-1:0]   cont_set,
  input  logic [IO_W-1:0]   io_set,
  input  logic [2:0]        clr_cmd,
  input  logic              io_inhibit,
  output logic [PE_W-1:0]   perr_ind,
  output logic [CT_W-1:0]   cont_ind,
  output logic [IO_W-1:0]   io_ind,
  output logic              dec_valid,
  output logic              dec_take,
  output logic [1:0]        dec_class,
  output logic [AW-1:0]     save_addr,
  output logic [WORD_W-1:0] save_word,
  output logic [AW-1:0]     next_addr,
  output logic              halted
);
  localparam int PAD_W = WORD_W - AW;

  logic [NCLS-1:0] pend;
  logic [NCLS-1:0] mode_q;
  logic            block_q;
  logic            halt_q;
  logic            decide;
  logic            take;
  cls_e            cls;
  logic [AW-1:0]   slot;
  logic [NCLS-1:0] take_hot;

  ind_bank #(.W(PE_W)) u_pe (
    .clk(clk), .rst_n(rst_n), .set_req(perr_set), .clr(clr_cmd[0]),
    .ind(perr_ind), .any(pend[0]));
  ind_bank #(.W(CT_W)) u_ct (
    .clk(clk), .rst_n(rst_n), .set_req(cont_set), .clr(clr_cmd[1]),
    .ind(cont_ind), .any(pend[1]));
  ind_bank #(.W(IO_W)) u_io (
    .clk(clk), .rst_n(rst_n), .set_req(io_set), .clr(clr_cmd[2]),
    .ind(io_ind), .any(pend[2]));

  prio_pick u_pick (
    .pend(pend), .mode(mode_q), .io_inhibit(io_inhibit),
    .blocked(block_q | (|clr_cmd)), .take(take), .cls(cls));

  assign decide = instr_done && !halt_q;
  assign slot   = AW'(VEC_BASE) + AW'({cls, 1'b0});

  always_comb begin
    take_hot = '0;
    if (decide && take) take_hot[cls] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      block_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      mode_q <= (mode_q & ~clr_cmd) | take_hot;
      if (|clr_cmd)    block_q <= 1'b1;
      else if (decide) block_q <= 1'b0;
      if ((|perr_set) && mode_q[0]) halt_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_take  <= 1'b0;
      dec_class <= '0;
      save_addr <= '0;
      save_word <= '0;
      next_addr <= '0;
    end else begin
      dec_valid <= decide;
      dec_take  <= decide && take;
      if (decide) begin
        dec_class <= take ? cls : CLS_PERR;
        save_addr <= take ? slot : '0;
        save_word <= {{PAD_W{1'b0}}, cur_pc};
        next_addr <= take ? slot + AW'(1) : cur_pc;
      end
    end
  end

  assign halted = halt_q;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int PE_W   = 4,
  parameter int CT_W   = 4,
  parameter int IO_W   = 4,
  parameter int AW     = 15,
  parameter int WORD_W = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_done,
  input logic [AW-1:0]     cur_pc,
  input logic [PE_W-1:0]   perr_set,
  input logic [CT_W-1:0]   cont_set,
  input logic [IO_W-1:0]   io_set,
  input logic [2:0]        clr_cmd,
  input logic              io_inhibit,
  input logic [PE_W-1:0]   perr_ind,
  input logic [CT_W-1:0]   cont_ind,
  input logic [IO_W-1:0]   io_ind,
  input logic              dec_valid,
  input logic              dec_take,
  input logic [1:0]        dec_class,
  input logic [AW-1:0]     save_addr,
  input logic [WORD_W-1:0] save_word,
  input logic [AW-1:0]     next_addr,
  input logic              halted
);
  p_valid_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(instr_done));

  p_take_has_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_take |-> dec_valid);

  p_slot_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_take |-> (next_addr == save_addr + AW'(1)) &&
                 (save_addr == AW'(16) + AW'({dec_class, 1'b0})));

  p_word_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_take |-> (save_word[WORD_W-1:AW] == '0) && (save_word[AW-1:0] == $past(cur_pc)));

  p_no_io_inhibited_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_take && dec_class == 2'd2) |-> !$past(io_inhibit));

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> !dec_valid);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    |io_set |=> ((io_ind & $past(io_set)) == $past(io_set)));

  p_resume_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_take) |-> next_addr == $past(cur_pc));
endmodule

bind trap_ctrl trap_ctrl_chk #(
  .PE_W(PE_W), .CT_W(CT_W), .IO_W(IO_W), .AW(AW), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/sim_trap_ctrl.sv
module sim_trap_ctrl;
  localparam int AW = 15;
  localparam int WW = 25;
  localparam int NSTEP = 16;

  // fields: [9] fault set, [8] contingency set, [7] io set, [6:4] clr_cmd,
  //         [3] io_inhibit, [2] expect trap, [1:0] expect class
  localparam logic [9:0] STEPS [NSTEP] = '{
    10'b0_0_1_000_0_1_10,  // io trap
    10'b0_1_0_000_0_1_01,  // contingency above io flag
    10'b0_0_0_000_0_0_00,  // io masked by own flag
    10'b0_0_0_100_0_0_00,  // clear io, blocked
    10'b0_0_1_000_0_0_00,  // io masked by contingency flag
    10'b0_0_0_010_0_0_00,  // clear contingency, blocked
    10'b0_0_0_000_1_0_00,  // io inhibited
    10'b0_0_0_000_0_1_10,  // io trap
    10'b1_1_0_000_0_1_00,  // fault wins
    10'b0_0_0_000_0_0_00,  // contingency masked by fault flag
    10'b0_0_0_001_0_0_00,  // clear fault, blocked
    10'b0_0_0_000_0_1_01,  // contingency trap
    10'b0_0_1_100_0_0_00,  // set races clear
    10'b0_0_0_000_0_0_00,  // io masked
    10'b0_0_0_010_0_0_00,  // clear contingency
    10'b0_0_0_000_0_1_10   // io trap: indicator survived race
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_done;
  logic [AW-1:0] cur_pc;
  logic [3:0]    perr_set, cont_set, io_set;
  logic [2:0]    clr_cmd;
  logic          io_inhibit;
  logic [3:0]    perr_ind, cont_ind, io_ind;
  logic          dec_valid, dec_take, halted;
  logic [1:0]    dec_class;
  logic [AW-1:0] save_addr, next_addr;
  logic [WW-1:0] save_word;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  trap_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .cur_pc(cur_pc),
    .perr_set(perr_set), .cont_set(cont_set), .io_set(io_set),
    .clr_cmd(clr_cmd), .io_inhibit(io_inhibit),
    .perr_ind(perr_ind), .cont_ind(cont_ind), .io_ind(io_ind),
    .dec_valid(dec_valid), .dec_take(dec_take), .dec_class(dec_class),
    .save_addr(save_addr), .save_word(save_word), .next_addr(next_addr),
    .halted(halted));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    instr_done = 0; perr_set = 0; cont_set = 0; io_set = 0; clr_cmd = 0;
  endtask

  // one set/clear cycle, then one completion cycle; returns after outputs settle
  task automatic step(input logic [2:0] sets, input logic [2:0] clr,
                      input logic inh, input logic [AW-1:0] pc);
    @(negedge clk);
    perr_set = {3'b0, sets[2]}; cont_set = {3'b0, sets[1]}; io_set = {3'b0, sets[0]};
    clr_cmd = clr; io_inhibit = inh;
    @(negedge clk);
    idle(); instr_done = 1; cur_pc = pc;
    @(negedge clk);
    instr_done = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); io_inhibit = 0; cur_pc = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(perr_ind == 0 && cont_ind == 0 && io_ind == 0, "R12 indicators", io_ind, 0);
    chk(!dec_valid && !dec_take && !halted, "R12 outputs", {dec_valid, dec_take, halted}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 no completion, no record
    repeat (3) @(negedge clk);
    chk(!dec_valid, "R1 no record without completion", dec_valid, 0);

    for (int i = 0; i < NSTEP; i++) begin
      logic [9:0]    v;
      logic [AW-1:0] pc;
      logic [AW-1:0] slot;
      v    = STEPS[i];
      pc   = AW'(100 + i * 37);
      slot = AW'(16 + 2 * int'(v[1:0]));
      step(v[9:7], v[6:4], v[3], pc);
      chk(dec_valid, $sformatf("R1 record step %0d", i), dec_valid, 1);
      chk(dec_take == v[2], $sformatf("R2 R3 R7 trap step %0d", i), dec_take, v[2]);
      if (v[2]) begin
        chk(dec_class == v[1:0], $sformatf("R2 class step %0d", i), dec_class, v[1:0]);
        chk(save_addr == slot, $sformatf("R4 save slot step %0d", i), save_addr, slot);
        chk(next_addr == slot + 1, $sformatf("R4 jump slot step %0d", i), next_addr, slot + 1);
        chk(save_word == {10'b0, pc}, $sformatf("R5 return word step %0d", i), save_word, pc);
      end else begin
        chk(next_addr == pc, $sformatf("R10 resume step %0d", i), next_addr, pc);
      end
      if (v[3]) chk(io_ind[0], "R9 io indicator kept while inhibited", io_ind[0], 1);
      if (i == 12) chk(io_ind[0], "R11 set beats clear", io_ind[0], 1);
    end
    io_inhibit = 0;

    // R6 clear touches only its own class
    @(negedge clk);
    perr_set = 4'b1010; cont_set = 4'b0110;
    @(negedge clk);
    idle(); clr_cmd = 3'b010;
    @(negedge clk);
    idle();
    chk(cont_ind == 0, "R6 contingency cleared", cont_ind, 0);
    chk(perr_ind == 4'b1010, "R6 fault untouched", perr_ind, 4'b1010);
    // blocked completion, then fault trap
    step(3'b000, 3'b000, 1'b0, 15'd500);
    chk(!dec_take, "R7 blocked after clear", dec_take, 0);
    step(3'b000, 3'b000, 1'b0, 15'd501);
    chk(dec_take && dec_class == 0, "R2 fault trap", dec_class, 0);
    chk(!halted, "R8 not yet halted", halted, 0);

    // R8 second fault while in service
    @(negedge clk);
    perr_set = 4'b0001;
    @(negedge clk);
    idle();
    chk(halted, "R8 halted", halted, 1);
    instr_done = 1;
    @(negedge clk);
    instr_done = 0;
    @(negedge clk);
    chk(!dec_valid, "R8 no record while halted", dec_valid, 0);
    chk(halted, "R8 halt sticky", halted, 1);

    // reset again
    rst_n = 0;
    @(negedge clk);
    chk(!halted && perr_ind == 0, "R12 reset clears halt", halted, 0);
    rst_n = 1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule